// File: doc/BRIEF.md
# Register ALU Execute Subset

This block is the execute stage for a small set of integer operations of a 32-bit RISC core. Each cycle in which `issueValid` is high, it decodes one 16-bit instruction word and reads the two register operands that the register file has already fetched. For the immediate form it also reads the 16-bit extension word. On the next clock edge it presents a writeback value, a write strobe, the destination register index and the updated condition flags.

The operations are subtract, reverse subtract, exclusive-OR, exclusive-OR with a zero-extended immediate, and a bitwise AND test that sets only the flags. There are also four single-register forms that sign- or zero-extend the low byte or low halfword of a register in place. The condition flags are carry/borrow (CY), overflow (OV), sign (S) and zero (Z). They live in a register inside the block. Any encoding outside this set raises `illegal` for one cycle and changes nothing.

Top module: `alu_exec_unit`

## Requirements
- R1: Two-register format: the reg2 index is in bits 15:11, the opcode in bits 10:5 and the reg1 index in bits 4:0. Opcode 001101 writes reg2 − reg1 to index reg2.
- R2: Opcode 001100 writes reg1 − reg2 to index reg2.
- R3: After subtract or reverse subtract, CY is 1 when the unsigned subtraction borrows and OV is 1 on two's-complement overflow. S equals result bit 31, and Z is 1 when the result is zero.
- R4: Opcode 001001 writes reg2 XOR reg1 to index reg2.
- R5: Opcode 110101 writes reg1 XOR the zero-extended 16-bit immediate `immWord` to index reg2.
- R6: Opcode 001011 forms reg2 AND reg1 for the flags only, and `wbEn` stays 0.
- R7: After XOR, XOR-immediate or test, OV is 0, S is result bit 31, Z is 1 when the result is zero, and CY keeps its previous value.
- R8: When bits 15:8 are zero and bit 7 is 1, the word is an extend of the reg1 register (bits 4:0), written back to that same index. Bit 6 selects halfword (1) or byte (0), and bit 5 selects sign (1) or zero (0) extension.
- R9: The extend forms leave CY, OV, S and Z unchanged.
- R10: Any other encoding sets `illegal` for the cycle after issue, with `wbEn` 0 and all flags unchanged.
- R11: Results, `wbEn` and `illegal` update on the clock edge that samples `issueValid` high. After an edge with `issueValid` low, `wbEn` and `illegal` are 0.
- R12: While reset is asserted, `wbEn`, `illegal`, `wbData`, `wbIndex` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Instruction and operands valid this cycle |
| instrWord | input | 16 | Instruction word |
| immWord | input | 16 | Immediate word for the XOR-immediate form |
| reg1Val | input | 32 | Value of the register named by bits 4:0 |
| reg2Val | input | 32 | Value of the register named by bits 15:11 |
| wbEn | output | 1 | Register write strobe |
| wbIndex | output | 5 | Destination register index |
| wbData | output | 32 | Writeback value |
| flagCy | output | 1 | Carry/borrow flag |
| flagOv | output | 1 | Overflow flag |
| flagS | output | 1 | Sign flag |
| flagZ | output | 1 | Zero flag |
| illegal | output | 1 | Unsupported encoding was issued |

## Verification
The assertions take for granted that `issueValid` is a known level after reset. They also assume that the instruction and operand inputs are stable and known in every cycle where `issueValid` is high. They do not check that the operand values belong to the indexed registers, because the register file owns that pairing. The stimulus changes every input only on the falling clock edge. Between issues the bench holds `issueValid` low. It supplies operands that it has chosen itself, paired with the index fields it encoded.

// File: rtl/alu_exec_pkg.sv
`timescale 1ns/1ps
package alu_exec_pkg;

  localparam int INSTR_W   = 16;
  localparam int REG_IDX_W = 5;
  localparam int OPC_W     = 6;

  localparam logic [OPC_W-1:0] OPC_SUB  = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_RSUB = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_XOR  = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_TEST = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'b110101;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SUB,
    OP_RSUB,
    OP_XOR,
    OP_XORI,
    OP_TEST,
    OP_EXT
  } opKind_e;

  // Strobes handed from decode to the datapath
  typedef struct packed {
    opKind_e                kind;
    logic                   writeEn;
    logic                   arithFlags;
    logic                   logicFlags;
    logic                   extSigned;
    logic                   extHalf;
    logic [REG_IDX_W-1:0]   destIdx;
    logic                   illegal;
  } ctrlStrobe_t;

endpackage

// File: rtl/alu_exec_ctrl.sv
`timescale 1ns/1ps
module alu_exec_ctrl
  import alu_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobe_t        ctrl
);

  localparam int REG2_LSB = INSTR_W - REG_IDX_W;
  localparam int OPC_LSB  = REG_IDX_W;

  logic [OPC_W-1:0]     opcode;
  logic [REG_IDX_W-1:0] reg1Idx;
  logic [REG_IDX_W-1:0] reg2Idx;
  logic                 isExtForm;

  assign opcode    = instrWord[OPC_LSB +: OPC_W];
  assign reg1Idx   = instrWord[REG_IDX_W-1:0];
  assign reg2Idx   = instrWord[REG2_LSB +: REG_IDX_W];
  // Single-register forms: upper byte clear, bit 7 set
  assign isExtForm = (instrWord[INSTR_W-1:8] == '0) && instrWord[7];

  always_comb begin
    ctrl      = '0;
    ctrl.kind = OP_NONE;
    if (isExtForm) begin
      ctrl.kind      = OP_EXT;
      ctrl.writeEn   = 1'b1;
      ctrl.extSigned = instrWord[5];
      ctrl.extHalf   = instrWord[6];
      ctrl.destIdx   = reg1Idx;
    end else begin
      ctrl.destIdx = reg2Idx;
      case (opcode)
        OPC_SUB: begin
          ctrl.kind       = OP_SUB;
          ctrl.writeEn    = 1'b1;
          ctrl.arithFlags = 1'b1;
        end
        OPC_RSUB: begin
          ctrl.kind       = OP_RSUB;
          ctrl.writeEn    = 1'b1;
          ctrl.arithFlags = 1'b1;
        end
        OPC_XOR: begin
          ctrl.kind       = OP_XOR;
          ctrl.writeEn    = 1'b1;
          ctrl.logicFlags = 1'b1;
        end
        OPC_XORI: begin
          ctrl.kind       = OP_XORI;
          ctrl.writeEn    = 1'b1;
          ctrl.logicFlags = 1'b1;
        end
        OPC_TEST: begin
          ctrl.kind       = OP_TEST;
          ctrl.logicFlags = 1'b1;
        end
        default: begin
          ctrl.illegal = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/alu_exec_dp.sv
`timescale 1ns/1ps
module alu_exec_dp
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  ctrlStrobe_t          ctrl,
  input  logic [IMM_W-1:0]     immWord,
  input  logic [DATA_W-1:0]    reg1Val,
  input  logic [DATA_W-1:0]    reg2Val,
  output logic                 wbEn,
  output logic [REG_IDX_W-1:0] wbIndex,
  output logic [DATA_W-1:0]    wbData,
  output logic                 flagCy,
  output logic                 flagOv,
  output logic                 flagS,
  output logic                 flagZ,
  output logic                 illegal
);

  localparam int MSB       = DATA_W - 1;
  localparam int EXT_KINDS = 2;   // byte, halfword

  logic [DATA_W-1:0] subA;
  logic [DATA_W-1:0] subB;
  logic [DATA_W-1:0] diff;
  logic              borrow;
  logic              overflow;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] result;
  logic [EXT_KINDS-1:0][DATA_W-1:0] extZero;
  logic [EXT_KINDS-1:0][DATA_W-1:0] extSign;
  logic              doWrite;
  logic              flagsFromWb;

  // One subtractor serves both operand orders
  assign subA = (ctrl.kind == OP_RSUB) ? reg1Val : reg2Val;
  assign subB = (ctrl.kind == OP_RSUB) ? reg2Val : reg1Val;
  assign {borrow, diff} = {1'b0, subA} - {1'b0, subB};
  assign overflow = (subA[MSB] ^ subB[MSB]) & (diff[MSB] ^ subA[MSB]);

  assign immExt = {{(DATA_W-IMM_W){1'b0}}, immWord};

  for (genvar k = 0; k < EXT_KINDS; k++) begin : g_ext
    localparam int W = 8 << k;
    assign extZero[k] = {{(DATA_W-W){1'b0}}, reg1Val[W-1:0]};
    assign extSign[k] = {{(DATA_W-W){reg1Val[W-1]}}, reg1Val[W-1:0]};
  end

  always_comb begin
    case (ctrl.kind)
      OP_SUB, OP_RSUB: result = diff;
      OP_XOR:          result = reg2Val ^ reg1Val;
      OP_XORI:         result = reg1Val ^ immExt;
      OP_TEST:         result = reg2Val & reg1Val;
      OP_EXT:          result = ctrl.extSigned ? extSign[ctrl.extHalf]
                                               : extZero[ctrl.extHalf];
      default:         result = '0;
    endcase
  end

  assign doWrite = issueValid & ctrl.writeEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn        <= 1'b0;
      wbIndex     <= '0;
      wbData      <= '0;
      illegal     <= 1'b0;
      flagCy      <= 1'b0;
      flagOv      <= 1'b0;
      flagS       <= 1'b0;
      flagZ       <= 1'b0;
      flagsFromWb <= 1'b0;
    end else begin
      wbEn        <= doWrite;
      illegal     <= issueValid & ctrl.illegal;
      flagsFromWb <= doWrite & (ctrl.arithFlags | ctrl.logicFlags);
      if (doWrite) begin
        wbData  <= result;
        wbIndex <= ctrl.destIdx;
      end
      if (issueValid && ctrl.arithFlags) begin
        flagCy <= borrow;
        flagOv <= overflow;
        flagS  <= result[MSB];
        flagZ  <= (result == '0);
      end else if (issueValid && ctrl.logicFlags) begin
        flagOv <= 1'b0;
        flagS  <= result[MSB];
        flagZ  <= (result == '0);
      end
    end
  end

  // R11: an idle edge clears the strobes
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!wbEn && !illegal));

  // R6: test never writes
  a_r6_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrl.kind == OP_TEST) |=> !wbEn);

  // R7: logical operations clear overflow and keep carry
  a_r7_logic_ov_clear: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrl.logicFlags) |=> (!flagOv && flagCy == $past(flagCy)));

  // R9: extends leave the flags alone
  a_r9_ext_flags_stable: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrl.kind == OP_EXT) |=> $stable({flagCy, flagOv, flagS, flagZ}));

  // R10: illegal encodings raise the flag and touch nothing else
  a_r10_illegal_inert: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrl.illegal) |=>
      (illegal && !wbEn && $stable({flagCy, flagOv, flagS, flagZ})));

  // R3 / R7: sign and zero track the value written back
  a_r3_sz_match_result: assert property (@(posedge clk) disable iff (!rstN)
    flagsFromWb |-> (flagZ == (wbData == '0) && flagS == wbData[MSB]));

  // R10 / R11: never write and flag illegal together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wbEn && illegal));

endmodule

// File: rtl/alu_exec_unit.sv
`timescale 1ns/1ps
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [IMM_W-1:0]     immWord,
  input  logic [DATA_W-1:0]    reg1Val,
  input  logic [DATA_W-1:0]    reg2Val,
  output logic                 wbEn,
  output logic [REG_IDX_W-1:0] wbIndex,
  output logic [DATA_W-1:0]    wbData,
  output logic                 flagCy,
  output logic                 flagOv,
  output logic                 flagS,
  output logic                 flagZ,
  output logic                 illegal
);

  ctrlStrobe_t ctrl;

  alu_exec_ctrl u_ctrl (
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  alu_exec_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .ctrl       (ctrl),
    .immWord    (immWord),
    .reg1Val    (reg1Val),
    .reg2Val    (reg2Val),
    .wbEn       (wbEn),
    .wbIndex    (wbIndex),
    .wbData     (wbData),
    .flagCy     (flagCy),
    .flagOv     (flagOv),
    .flagS      (flagS),
    .flagZ      (flagZ),
    .illegal    (illegal)
  );

endmodule

// File: tb/alu_exec_unit_test.sv
`timescale 1ns/1ps
module alu_exec_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] immWord = '0;
  logic [31:0] reg1Val = '0;
  logic [31:0] reg2Val = '0;
  logic        wbEn;
  logic [4:0]  wbIndex;
  logic [31:0] wbData;
  logic        flagCy, flagOv, flagS, flagZ;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model flags {cy, ov, s, z}
  logic [3:0] mFlags = 4'b0000;

  always #5 clk = ~clk;

  alu_exec_unit uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .immWord(immWord), .reg1Val(reg1Val), .reg2Val(reg2Val), .wbEn(wbEn),
    .wbIndex(wbIndex), .wbData(wbData), .flagCy(flagCy), .flagOv(flagOv),
    .flagS(flagS), .flagZ(flagZ), .illegal(illegal)
  );

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] imm;
    logic [31:0] r1;
    logic [31:0] r2;
    logic        expWe;
    logic        expIll;
    logic [4:0]  expIdx;
    logic [31:0] expData;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{{5'd3, 6'b001101, 5'd1},  16'h0000, 32'd3,        32'd10,       1'b1, 1'b0, 5'd3,  32'd7},        // R1
    '{{5'd4, 6'b001100, 5'd2},  16'h0000, 32'd3,        32'd10,       1'b1, 1'b0, 5'd4,  32'hFFFFFFF9}, // R2
    '{{5'd5, 6'b001001, 5'd6},  16'h0000, 32'hF0F0F0F0, 32'h0FF00FF0, 1'b1, 1'b0, 5'd5,  32'hFF00FF00}, // R4
    '{{5'd7, 6'b110101, 5'd8},  16'hFFFF, 32'h12345678, 32'h0,        1'b1, 1'b0, 5'd7,  32'h1234A987}, // R5
    '{{5'd9, 6'b001011, 5'd10}, 16'h0000, 32'h000000FF, 32'h00000100, 1'b0, 1'b0, 5'd0,  32'h0},        // R6
    '{16'h008B,                 16'h0000, 32'h12345688, 32'h0,        1'b1, 1'b0, 5'd11, 32'h00000088}, // R8 zero byte
    '{16'h00AB,                 16'h0000, 32'h12345688, 32'h0,        1'b1, 1'b0, 5'd11, 32'hFFFFFF88}, // R8 sign byte
    '{16'h00CB,                 16'h0000, 32'h1234F688, 32'h0,        1'b1, 1'b0, 5'd11, 32'h0000F688}, // R8 zero half
    '{16'h00EB,                 16'h0000, 32'h1234F688, 32'h0,        1'b1, 1'b0, 5'd11, 32'hFFFFF688}, // R8 sign half
    '{16'h0000,                 16'h0000, 32'h1,        32'h2,        1'b0, 1'b1, 5'd0,  32'h0},        // R10
    '{{5'd1, 6'b111111, 5'd1},  16'h0000, 32'h1,        32'h2,        1'b0, 1'b1, 5'd0,  32'h0}         // R10
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference, written from the requirements
  task automatic model(input logic [15:0] ins, input logic [15:0] imm,
                       input logic [31:0] a1, input logic [31:0] a2,
                       output logic we, output logic ill,
                       output logic [4:0] idx, output logic [31:0] data);
    logic [5:0] opc;
    longint sd;
    opc = ins[10:5];
    we = 1'b0; ill = 1'b0; idx = ins[15:11]; data = '0;
    if (ins[15:8] == 8'h00 && ins[7]) begin
      we = 1'b1; idx = ins[4:0];
      case (ins[6:5])
        2'b00: data = {24'h0, a1[7:0]};
        2'b01: data = {{24{a1[7]}}, a1[7:0]};
        2'b10: data = {16'h0, a1[15:0]};
        default: data = {{16{a1[15]}}, a1[15:0]};
      endcase
    end else if (opc == 6'b001101 || opc == 6'b001100) begin
      logic [31:0] x, y;
      x = (opc == 6'b001101) ? a2 : a1;
      y = (opc == 6'b001101) ? a1 : a2;
      we = 1'b1;
      data = x - y;
      sd = longint'($signed(x)) - longint'($signed(y));
      mFlags[3] = (x < y);
      mFlags[2] = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      mFlags[1] = data[31];
      mFlags[0] = (data == 0);
    end else if (opc == 6'b001001 || opc == 6'b110101 || opc == 6'b001011) begin
      if (opc == 6'b001001) data = a1 ^ a2;
      else if (opc == 6'b110101) data = a1 ^ {16'h0, imm};
      else data = a1 & a2;
      we = (opc != 6'b001011);
      mFlags[2] = 1'b0;
      mFlags[1] = data[31];
      mFlags[0] = (data == 0);
    end else begin
      ill = 1'b1;
    end
  endtask

  task automatic issue(input logic [15:0] ins, input logic [15:0] imm,
                       input logic [31:0] a1, input logic [31:0] a2);
    @(negedge clk);
    instrWord = ins; immWord = imm; reg1Val = a1; reg2Val = a2;
    issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic run_and_compare(input logic [15:0] ins, input logic [15:0] imm,
                                 input logic [31:0] a1, input logic [31:0] a2,
                                 input string req);
    logic we, ill;
    logic [4:0] idx;
    logic [31:0] data;
    model(ins, imm, a1, a2, we, ill, idx, data);
    issue(ins, imm, a1, a2);
    check(wbEn == we, {req, " wbEn"}, 32'(wbEn), 32'(we));
    check(illegal == ill, {req, " illegal"}, 32'(illegal), 32'(ill));
    if (we) begin
      check(wbData == data, {req, " data"}, wbData, data);
      check(wbIndex == idx, {req, " index"}, 32'(wbIndex), 32'(idx));
    end
    check({flagCy, flagOv, flagS, flagZ} == mFlags, {req, " flags"},
          32'({flagCy, flagOv, flagS, flagZ}), 32'(mFlags));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    // R12: reset state
    repeat (3) @(negedge clk);
    check({wbEn, illegal, flagCy, flagOv, flagS, flagZ} == 6'b0, "R12 strobes/flags",
          32'({wbEn, illegal, flagCy, flagOv, flagS, flagZ}), 32'h0);
    check(wbData == 32'h0 && wbIndex == 5'd0, "R12 data/index", wbData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: R1 R2 R4 R5 R6 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      logic we, ill;
      logic [4:0] idx;
      logic [31:0] data;
      model(VECS[i].instr, VECS[i].imm, VECS[i].r1, VECS[i].r2, we, ill, idx, data);
      issue(VECS[i].instr, VECS[i].imm, VECS[i].r1, VECS[i].r2);
      check(wbEn == VECS[i].expWe, "R1/R6 table wbEn", 32'(wbEn), 32'(VECS[i].expWe));
      check(illegal == VECS[i].expIll, "R10 table illegal", 32'(illegal), 32'(VECS[i].expIll));
      if (VECS[i].expWe) begin
        check(wbData == VECS[i].expData, "R2/R4/R5/R8 table data", wbData, VECS[i].expData);
        check(wbIndex == VECS[i].expIdx, "R1/R8 table index", 32'(wbIndex), 32'(VECS[i].expIdx));
      end
      check({flagCy, flagOv, flagS, flagZ} == mFlags, "R3/R7/R9 table flags",
            32'({flagCy, flagOv, flagS, flagZ}), 32'(mFlags));
    end

    // R11: idle edge clears strobes
    issue({5'd2, 6'b001101, 5'd2}, 16'h0, 32'd1, 32'd5);
    @(negedge clk);
    check(!wbEn && !illegal, "R11 idle clears", 32'({wbEn, illegal}), 32'h0);
    mFlags = 4'b0000;  // 5-1: no borrow, no overflow, positive, nonzero

    // R3 corners
    issue({5'd3, 6'b001101, 5'd4}, 16'h0, 32'd1, 32'h80000000);
    check(wbData == 32'h7FFFFFFF, "R3 min-1 data", wbData, 32'h7FFFFFFF);
    check({flagCy, flagOv, flagS, flagZ} == 4'b0100, "R3 min-1 flags",
          32'({flagCy, flagOv, flagS, flagZ}), 32'h4);
    issue({5'd3, 6'b001101, 5'd4}, 16'h0, 32'd1, 32'h0);
    check(wbData == 32'hFFFFFFFF, "R3 zero-1 data", wbData, 32'hFFFFFFFF);
    check({flagCy, flagOv, flagS, flagZ} == 4'b1010, "R3 zero-1 flags",
          32'({flagCy, flagOv, flagS, flagZ}), 32'hA);
    // R7: logic keeps CY=1, clears OV, Z on zero result
    issue({5'd3, 6'b001011, 5'd4}, 16'h0, 32'h0F, 32'hF0);
    check({flagCy, flagOv, flagS, flagZ} == 4'b1001, "R7 test keeps CY",
          32'({flagCy, flagOv, flagS, flagZ}), 32'h9);
    held = {flagCy, flagOv, flagS, flagZ};
    // R9: extend leaves flags
    issue(16'h00E5, 16'h0, 32'h00008000, 32'h0);
    check({flagCy, flagOv, flagS, flagZ} == held, "R9 extend flags held",
          32'({flagCy, flagOv, flagS, flagZ}), 32'(held));
    check(wbData == 32'hFFFF8000 && wbIndex == 5'd5, "R8 sign half idx5", wbData, 32'hFFFF8000);
    // R3: equal operands give Z
    issue({5'd6, 6'b001100, 5'd7}, 16'h0, 32'h1234, 32'h1234);
    check({flagCy, flagOv, flagS, flagZ} == 4'b0001, "R3 equal zero",
          32'({flagCy, flagOv, flagS, flagZ}), 32'h1);
    mFlags = 4'b0001;

    // Random comparison against the reference
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ins;
      logic [4:0] ra, rb;
      logic [31:0] a1, a2;
      int pick;
      ra = 5'($urandom); rb = 5'($urandom);
      a1 = $urandom; a2 = $urandom;
      if (n % 8 == 0) a1 = a2;
      pick = $urandom_range(0, 9);
      case (pick)
        0: ins = {rb, 6'b001101, ra};
        1: ins = {rb, 6'b001100, ra};
        2: ins = {rb, 6'b001001, ra};
        3: ins = {rb, 6'b110101, ra};
        4: ins = {rb, 6'b001011, ra};
        5: ins = {8'h00, 1'b1, 2'($urandom), ra};
        6: ins = {rb, 6'b000000, ra};
        7: ins = {rb, 6'b001101, ra};
        8: ins = {rb, 6'b001100, ra};
        default: ins = {rb, 6'b011110, ra};
      endcase
      run_and_compare(ins, 16'($urandom), a1, a2, "R1-random R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule